// File: doc/BRIEF.md
# SPI Flash Command Engine with Shared Byte Ring

This block is a memory-mapped SPI master that runs one serial-flash command per start. The command opcode sits in its own register and always goes out first. It is followed by a programmed number of write bytes and then a programmed number of response bytes. The write bytes come from an 8-entry byte ring. That same ring receives the MISO byte sampled during every byte after the opcode, so one structure acts as both the transmit source and the receive sink.

Software fills the ring through one data port whose 3-bit pointer advances on each access. It can read the pointer and can set it back to zero. It programs the counts and the opcode and then sets the start bit. Once chip select is released, it resets the pointer, skips the entries that echo the write bytes, and reads the response. The engine's own ring index always starts at entry 0 and does not depend on the software pointer.

Top module: `spi_cmd_engine`

## Requirements
- R1: The opcode register at address 0x0 is shifted out first on MOSI, MSB first, and never passes through the ring.
- R2: Address 0x1 holds the read byte count in bits 7:4 and the write byte count (opcode excluded) in bits 3:0. The write bytes are sent from ring entries 0, 1, 2 and so on, in that order.
- R3: A write to the data port at 0xC stores the byte at the ring entry the pointer selects and then advances the pointer. The 3-bit pointer wraps modulo 8.
- R4: Hardware never clears the ring. Any write to 0xD resets the pointer to 0 and leaves the ring contents untouched.
- R5: The MISO byte sampled during the k-th byte after the opcode (k from 0) is stored into ring entry k mod 8. The echoes of the write bytes therefore come first and the read data follows them.
- R6: With a write count of zero, all of the read-count response bytes are captured, including the last one.
- R7: A read of 0xC returns the entry at the pointer and then advances the pointer. Bits 2:0 of a read at 0xD return the pointer.
- R8: MOSI is held at 0 during every read-phase byte.
- R9: Writing 1 to bit 0 at 0x2 starts a transaction, and reading bit 0 at 0x2 returns busy. While busy, every bus write is ignored: start, opcode, counts, data and pointer reset.
- R10: The bus uses SPI mode 0, with SCK equal to clk/4 and MOSI driven while SCK is low. For N bytes after the opcode, CS# stays low for exactly 32*N+34 cycles. SCK is low in the first and last of those cycles and at all times while CS# is high.
- R11: Transactions longer than 8 bytes wrap the engine's ring index, so later responses overwrite earlier entries.
- R12: A synchronous active-high reset raises CS#, lowers SCK, clears busy and sets the opcode, the counts and the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on the data port) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Master out |
| spi_miso | input | 1 | Master in |

## Verification
Read data appears in the same cycle as the address. A pointer change caused by a write or read strobe is visible one edge later, so the bench samples `bus_rdata` 1 ns after it drives the address at a falling edge. CS# falls on the edge that takes the start write, and SCK first rises 3 cycles later. CS# rises again 32*N+34 cycles after it fell. A per-clock model in the bench counts cycles from the CS# fall and predicts SCK for every falling-edge sample. It also checks the length of every low window, and the ring is read back only after CS# has risen.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int DATA_W     = 8;
    localparam int RING_DEPTH = 8;
    localparam int PTR_W      = $clog2(RING_DEPTH);
    localparam int CNT_W      = 4;
    localparam int ADDR_W     = 4;
    localparam int SCK_DIV    = 4;
    localparam int PH_W       = $clog2(SCK_DIV);
    localparam int SCK_HALF   = SCK_DIV / 2;
    localparam int BYTE_W     = CNT_W + 1;

    localparam logic [ADDR_W-1:0] A_OPCODE = 4'h0;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'h1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'h2;
    localparam logic [ADDR_W-1:0] A_DATA   = 4'hC;
    localparam logic [ADDR_W-1:0] A_PTR    = 4'hD;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD
    } eng_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] opcode;
        logic [CNT_W-1:0]  rd_cnt;
        logic [CNT_W-1:0]  wr_cnt;
    } xfer_cfg_t;

    function automatic logic [BYTE_W-1:0] total_bytes(input xfer_cfg_t c);
        return {1'b0, c.rd_cnt} + {1'b0, c.wr_cnt};
    endfunction

    function automatic logic [PTR_W-1:0] ring_slot(input logic [BYTE_W-1:0] n);
        return n[PTR_W-1:0];
    endfunction
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    output xfer_cfg_t         cfg,
    output logic              start_pulse,
    input  logic [PTR_W-1:0]  eng_rd_idx,
    output logic [DATA_W-1:0] eng_rd_data,
    input  logic              eng_wr_en,
    input  logic [PTR_W-1:0]  eng_wr_idx,
    input  logic [DATA_W-1:0] eng_wr_data
);
    logic [DATA_W-1:0] ring [RING_DEPTH];
    logic [PTR_W-1:0]  ptr;
    logic              bus_wr_ok;

    assign bus_wr_ok   = wr_en && !busy;
    assign start_pulse = bus_wr_ok && (addr == A_CTRL) && wdata[0];
    assign eng_rd_data = ring[eng_rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            ptr <= '0;
        end else if (bus_wr_ok) begin
            case (addr)
                A_OPCODE: cfg.opcode <= wdata;
                A_COUNT:  {cfg.rd_cnt, cfg.wr_cnt} <= wdata;
                A_DATA:   ptr <= ptr + PTR_W'(1);
                A_PTR:    ptr <= '0;
                default:  ;
            endcase
        end else if (rd_en && addr == A_DATA) begin
            ptr <= ptr + PTR_W'(1);
        end
    end

    // Ring storage carries no reset: contents survive everything.
    always_ff @(posedge clk) begin
        if (eng_wr_en)
            ring[eng_wr_idx] <= eng_wr_data;
        else if (bus_wr_ok && addr == A_DATA)
            ring[ptr] <= wdata;
    end

    always_comb begin
        case (addr)
            A_OPCODE: rdata = cfg.opcode;
            A_COUNT:  rdata = {cfg.rd_cnt, cfg.wr_cnt};
            A_CTRL:   rdata = {{(DATA_W-1){1'b0}}, busy};
            A_DATA:   rdata = ring[ptr];
            A_PTR:    rdata = {{(DATA_W-PTR_W){1'b0}}, ptr};
            default:  rdata = '0;
        endcase
    end

    // R9: configuration is frozen while a transaction runs
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg));

    // R7: a data-port read with no write advances the pointer by one
    a_r7_read_advances: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && addr == A_DATA) |=> ptr == $past(ptr) + PTR_W'(1));

    // R4: a pointer reset write brings the pointer to zero
    a_r4_ptr_reset: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_ok && addr == A_PTR) |=> ptr == '0);
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_cfg_t         cfg,
    output logic              busy,
    output logic [PTR_W-1:0]  ring_rd_idx,
    input  logic [DATA_W-1:0] ring_rd_data,
    output logic              ring_wr_en,
    output logic [PTR_W-1:0]  ring_wr_idx,
    output logic [DATA_W-1:0] ring_wr_data,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    eng_state_e              st;
    logic [PH_W-1:0]         phase;
    logic [2:0]              bit_cnt;
    logic [BYTE_W-1:0]       byte_num;
    logic [DATA_W-1:0]       tx_sh, rx_sh, next_tx;
    logic [BYTE_W-1:0]       n_total;
    logic                    byte_end, sample_now;

    assign n_total    = total_bytes(cfg);
    assign sample_now = (st == ST_SHIFT) && (phase == PH_W'(SCK_HALF));
    assign byte_end   = (st == ST_SHIFT) && (phase == PH_W'(SCK_DIV-1)) && (bit_cnt == 3'd0);

    // Byte n+1 uses ring entry n; write-phase bytes come from the ring.
    assign ring_rd_idx = ring_slot(byte_num);
    assign next_tx     = (byte_num < {1'b0, cfg.wr_cnt}) ? ring_rd_data : '0;

    assign ring_wr_en   = byte_end && (byte_num != '0);
    assign ring_wr_idx  = ring_slot(byte_num - BYTE_W'(1));
    assign ring_wr_data = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            phase    <= '0;
            bit_cnt  <= '0;
            byte_num <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st       <= ST_SETUP;
                    tx_sh    <= cfg.opcode;
                    byte_num <= '0;
                    bit_cnt  <= 3'd7;
                    phase    <= '0;
                end
                ST_SETUP: st <= ST_SHIFT;
                ST_SHIFT: begin
                    phase <= phase + PH_W'(1);
                    if (sample_now)
                        rx_sh <= {rx_sh[DATA_W-2:0], spi_miso};
                    if (phase == PH_W'(SCK_DIV-1)) begin
                        if (bit_cnt == 3'd0) begin
                            if (byte_num == n_total) begin
                                st <= ST_HOLD;
                            end else begin
                                byte_num <= byte_num + BYTE_W'(1);
                                tx_sh    <= next_tx;
                                bit_cnt  <= 3'd7;
                            end
                        end else begin
                            bit_cnt <= bit_cnt - 3'd1;
                            tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                ST_HOLD: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign spi_cs_n = (st == ST_IDLE);
    assign spi_sck  = (st == ST_SHIFT) && (phase >= PH_W'(SCK_HALF));
    assign spi_mosi = (st == ST_SHIFT) && tx_sh[DATA_W-1];

    // R10: no clock pulses with chip select released
    a_r10_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R10: select leads the first SCK edge by at least a cycle
    a_r10_cs_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |=> !spi_sck);

    // R8: read-phase bytes drive zero on MOSI
    a_r8_mosi_zero: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT && byte_num > {1'b0, cfg.wr_cnt}) |-> !spi_mosi);

    // R6: the final response byte is written before chip select rises
    a_r6_last_kept: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && n_total != '0) |-> $past(ring_wr_en));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    xfer_cfg_t         cfg;
    logic              busy, start_pulse;
    logic [PTR_W-1:0]  rd_idx, wr_idx;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;

    spi_cmd_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .addr        (bus_addr),
        .wr_en       (bus_wr),
        .rd_en       (bus_rd),
        .wdata       (bus_wdata),
        .rdata       (bus_rdata),
        .busy        (busy),
        .cfg         (cfg),
        .start_pulse (start_pulse),
        .eng_rd_idx  (rd_idx),
        .eng_rd_data (rd_data),
        .eng_wr_en   (wr_en),
        .eng_wr_idx  (wr_idx),
        .eng_wr_data (wr_data)
    );

    spi_cmd_shifter u_shift (
        .clk          (clk),
        .rst          (rst),
        .start        (start_pulse),
        .cfg          (cfg),
        .busy         (busy),
        .ring_rd_idx  (rd_idx),
        .ring_rd_data (rd_data),
        .ring_wr_en   (wr_en),
        .ring_wr_idx  (wr_idx),
        .ring_wr_data (wr_data),
        .spi_cs_n     (spi_cs_n),
        .spi_sck      (spi_sck),
        .spi_mosi     (spi_mosi),
        .spi_miso     (spi_miso)
    );
endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst = 1;
    logic [3:0] bus_addr = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    spi_cmd_engine dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Flash slave model: mode 0, shifts on falling SCK, resp[0] covers the opcode
    logic [7:0] resp [0:31];
    logic [7:0] bitidx = 0;
    always @(negedge spi_cs_n) bitidx = 0;
    always @(negedge spi_sck) if (!spi_cs_n) bitidx = bitidx + 1;
    assign spi_miso = resp[bitidx[7:3]][~bitidx[2:0]];

    // MOSI monitor
    logic [7:0] mlog [0:31];
    logic [7:0] msh = 0;
    int mcount = 0;
    always @(posedge spi_sck) begin
        msh = {msh[6:0], spi_mosi};
        mcount++;
        if (mcount % 8 == 0) mlog[mcount/8 - 1] = msh;
    end

    // Per-clock reference model of CS#/SCK timing (R10)
    int  exp_len = 0, lowk = 0;
    bit  model_on = 1;
    always @(negedge clk) begin
        if (rst) lowk = 0;
        else if (!spi_cs_n) begin
            chk("R10 sck", int'(spi_sck),
                int'(lowk >= 1 && lowk <= exp_len - 2 && ((lowk - 1) % 4) >= 2));
            lowk++;
        end else begin
            if (lowk != 0) begin
                if (model_on) chk("R10 cs_low_len", lowk, exp_len);
                lowk = 0;
            end
            chk("R10 sck_idle", int'(spi_sck), 0);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic chk_rd(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, int'(v), int'(exp));
    endtask

    task automatic xfer(input logic [7:0] opc, input int w, input int r);
        wr(4'h0, opc);
        wr(4'h1, 8'((r << 4) | w));
        exp_len = 32 * (w + r) + 34;
        mcount = 0;
        wr(4'h2, 8'h01);
        @(posedge spi_cs_n);
        @(negedge clk);
    endtask

    task automatic ring_check(input string req, input logic [7:0] e0, e1, e2, e3,
                              input logic [7:0] e4, e5, e6, e7);
        logic [7:0] ex [8];
        ex = '{e0, e1, e2, e3, e4, e5, e6, e7};
        wr(4'hD, 8'h00);
        for (int i = 0; i < 8; i++) chk_rd(req, 4'hC, ex[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 32; i++) resp[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        // R12 reset state
        chk("R12 cs_n", int'(spi_cs_n), 1);
        chk_rd("R12 busy", 4'h2, 8'h00);
        chk_rd("R12 ptr", 4'hD, 8'h00);
        chk_rd("R12 opcode", 4'h0, 8'h00);

        // R3 data-port fill with wrap
        for (int i = 0; i < 10; i++) wr(4'hC, 8'hA0 + 8'(i));
        chk_rd("R3 ptr_wrap", 4'hD, 8'h02);
        // R7 read steps pointer
        wr(4'hD, 8'h00);
        chk_rd("R7 rd0", 4'hC, 8'hA8);
        chk_rd("R7 rd1", 4'hC, 8'hA9);
        chk_rd("R7 ptr", 4'hD, 8'h02);
        ring_check("R3 R4 ring", 8'hA8, 8'hA9, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7);

        // R1 R2 R5 R8: opcode, three writes, two reads
        wr(4'hD, 8'h00);
        wr(4'hC, 8'h11); wr(4'hC, 8'h22); wr(4'hC, 8'h33);
        chk_rd("R2 count_reg", 4'h1, 8'h00);
        resp[1] = 8'hC1; resp[2] = 8'hC2; resp[3] = 8'hC3; resp[4] = 8'hD4; resp[5] = 8'hD5;
        xfer(8'h5A, 3, 2);
        chk_rd("R2 count_reg", 4'h1, 8'h23);
        chk("R1 mosi_bytes", mcount, 48);
        chk("R1 opcode_first", int'(mlog[0]), 'h5A);
        chk("R2 w0", int'(mlog[1]), 'h11);
        chk("R2 w1", int'(mlog[2]), 'h22);
        chk("R2 w2", int'(mlog[3]), 'h33);
        chk("R8 r0", int'(mlog[4]), 0);
        chk("R8 r1", int'(mlog[5]), 0);
        ring_check("R5 R4 ring", 8'hC1, 8'hC2, 8'hC3, 8'hD4, 8'hD5, 8'hA5, 8'hA6, 8'hA7);

        // R6: zero write bytes, four reads
        for (int i = 0; i < 4; i++) resp[1+i] = 8'h81 + 8'(i);
        xfer(8'h05, 0, 4);
        chk("R8 ro", int'(mlog[4]), 0);
        ring_check("R6 ring", 8'h81, 8'h82, 8'h83, 8'h84, 8'hD5, 8'hA5, 8'hA6, 8'hA7);

        // R11: ten bytes wrap the engine index
        wr(4'hD, 8'h00);
        wr(4'hC, 8'h3C); wr(4'hC, 8'h4D);
        for (int i = 0; i < 10; i++) resp[1+i] = 8'hE0 + 8'(i);
        xfer(8'h0B, 2, 8);
        chk("R11 w0", int'(mlog[1]), 'h3C);
        chk("R11 w1", int'(mlog[2]), 'h4D);
        chk("R8 last", int'(mlog[10]), 0);
        ring_check("R11 ring", 8'hE8, 8'hE9, 8'hE2, 8'hE3, 8'hE4, 8'hE5, 8'hE6, 8'hE7);

        // R1 R6: opcode only
        xfer(8'h06, 0, 0);
        chk("R1 op_only_bits", mcount, 8);
        chk("R1 op_only", int'(mlog[0]), 'h06);
        ring_check("R4 untouched", 8'hE8, 8'hE9, 8'hE2, 8'hE3, 8'hE4, 8'hE5, 8'hE6, 8'hE7);

        // R9: bus writes ignored while busy
        wr(4'hD, 8'h00);
        for (int i = 0; i < 5; i++) rd(4'hC, v);
        resp[1] = 8'h71; resp[2] = 8'h72;
        wr(4'h0, 8'h3B);
        wr(4'h1, 8'h11);
        exp_len = 98;
        mcount = 0;
        wr(4'h2, 8'h01);
        repeat (4) @(negedge clk);
        chk_rd("R9 busy", 4'h2, 8'h01);
        wr(4'h0, 8'hFF);
        wr(4'h1, 8'h77);
        wr(4'hC, 8'h99);
        wr(4'hD, 8'h00);
        wr(4'h2, 8'h01);
        @(posedge spi_cs_n);
        @(negedge clk);
        chk_rd("R9 opcode_kept", 4'h0, 8'h3B);
        chk_rd("R9 count_kept", 4'h1, 8'h11);
        chk_rd("R9 ptr_kept", 4'hD, 8'h05);
        chk_rd("R9 data_ignored", 4'hC, 8'hE5);
        chk("R9 mosi_w0", int'(mlog[1]), 'hE8);
        repeat (50) @(negedge clk);
        chk("R9 no_restart", int'(spi_cs_n), 1);
        chk_rd("R9 idle", 4'h2, 8'h00);
        ring_check("R5 ring", 8'h71, 8'h72, 8'hE2, 8'hE3, 8'hE4, 8'hE5, 8'hE6, 8'hE7);

        // R12: reset in mid transaction
        wr(4'h1, 8'h20);
        exp_len = 98;
        model_on = 0;
        wr(4'h2, 8'h01);
        repeat (20) @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R12 cs_abort", int'(spi_cs_n), 1);
        chk("R12 sck_abort", int'(spi_sck), 0);
        chk_rd("R12 busy_abort", 4'h2, 8'h00);
        chk_rd("R12 opcode_abort", 4'h0, 8'h00);
        chk_rd("R12 count_abort", 4'h1, 8'h00);
        chk_rd("R12 ptr_abort", 4'hD, 8'h00);
        model_on = 1;
        repeat (5) @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule